// File: doc/BRIEF.md
# Flag-Setting Word/Byte ALU

This block is the arithmetic and logic stage of a small two-operand microcontroller datapath. It takes a destination operand, a source operand, a 4-bit operation code, a byte/word size select and the four incoming condition flags (carry C, zero Z, negative N, overflow V). From these it produces a result, a write-enable that tells the register stage whether to store that result, and the new flag values. The operations are addition (with and without carry), subtraction (with and without borrow), compare, AND, bit-test, bit-clear, bit-set, XOR, and single-bit shifts and rotates.

Subtraction is performed as dest + NOT(src) + carry-in, so C=1 after a subtract means no borrow and C=0 means a borrow happened. Compare and bit-test update only the flags. In byte mode both operands are cut to their low 8 bits, and the result has its upper byte forced to zero. Carry and sign are then taken at bit 7 instead of bit 15.

Inputs are sampled on each rising clock edge, and all outputs come from registers. Results therefore appear one cycle after the operands are presented. A synchronous active-high reset clears all outputs.

Top module: `flag_alu`

## Requirements
- R1: While reset is high at a rising edge, all outputs become 0 after that edge (result, write-enable and all four flags).
- R2: Opcode 0 (add) gives dest+src, and the incoming C has no effect. Opcode 1 (add with carry) gives dest+src+C. C out is the carry out of the active most significant bit.
- R3: Opcode 2 (subtract) gives dest+NOT(src)+1, and the incoming C has no effect. Opcode 3 (subtract with borrow) gives dest+NOT(src)+C. C out is the carry out of the active MSB, so C=0 means a borrow occurred.
- R4: On add, V=1 when the operands have the same sign and the result sign differs from it. On subtract and compare, V=1 when the operand signs differ and the result sign differs from the destination sign.
- R5: Opcode 4 (compare, same as subtract with carry-in 1) and opcode 6 (bit-test, dest AND src) update the flags with write-enable 0. The result output still carries the computed value.
- R6: Z=1 exactly when the result at the active size is zero. N equals the result bit 15 in word mode and bit 7 in byte mode.
- R7: Opcode 5 gives dest AND src, opcode 7 gives dest AND NOT src, opcode 8 gives dest OR src and opcode 9 gives dest XOR src. For these opcodes and for bit-test, V=0 and C=NOT Z.
- R8: When the byte select is 1, only bits 7:0 of both operands are used. Result bits 15:8 are 0, and carry and sign come from bit 7.
- R9: Opcode 10 shifts right logically (0 into the MSB, old LSB into C). Opcode 11 shifts left (0 into the LSB, old active MSB into C). V=0 for both.
- R10: Opcode 12 shifts right arithmetically (MSB kept, old LSB into C). Opcode 13 rotates right through carry (old C into the MSB, old LSB into C). V=0 for both.
- R11: Opcodes 14 and 15 produce write-enable 0 and result 0, and pass the incoming four flags through unchanged.
- R12: Outputs reflect the inputs sampled at the previous rising edge (one cycle latency).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code |
| byte_i | input | 1 | 1 = byte operation, 0 = word operation |
| dst_i | input | 16 | Destination operand |
| src_i | input | 16 | Source operand or mask |
| c_i | input | 1 | Incoming carry flag |
| z_i | input | 1 | Incoming zero flag |
| n_i | input | 1 | Incoming negative flag |
| v_i | input | 1 | Incoming overflow flag |
| res_o | output | 16 | Registered result |
| wr_o | output | 1 | Registered result write-enable |
| c_o | output | 1 | Updated carry flag |
| z_o | output | 1 | Updated zero flag |
| n_o | output | 1 | Updated negative flag |
| v_o | output | 1 | Updated overflow flag |

## Verification
The bench targets several corner cases:
- Signed overflow at 0x7FFF+1 and 0x8000-1. A design with the sign test inverted misses V, or sets it on benign sums.
- Byte adds whose operands carry junk in the upper byte. A design that forgets to mask leaks the upper byte into the result, or takes the carry from bit 15 instead of bit 7.
- Subtracts where the destination is smaller than the source, and subtract-with-borrow with C=0. These expose a carry sense read as "borrow=1", or a carry-in that ignores C.
- Rotates with C=1 and arithmetic shifts of negative bytes. These catch a fill bit placed at bit 15 during byte mode.

Compare, bit-test and the two unused opcodes are also driven. A design that wrote the result for these, or altered the flags on the unused opcodes, would be caught.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,  OP_ADDC = 4'd1,  OP_SUB  = 4'd2,  OP_SUBB = 4'd3,
    OP_CMP  = 4'd4,  OP_AND  = 4'd5,  OP_TST  = 4'd6,  OP_BIC  = 4'd7,
    OP_BIS  = 4'd8,  OP_XOR  = 4'd9,  OP_SRL  = 4'd10, OP_SLL  = 4'd11,
    OP_SRA  = 4'd12, OP_RRC  = 4'd13, OP_RS14 = 4'd14, OP_RS15 = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {U_ARITH, U_LOGIC, U_SHIFT, U_NONE} unit_e;
  typedef enum logic [1:0] {L_AND, L_ANDN, L_OR, L_XOR} logic_e;
  typedef enum logic [1:0] {S_LSR, S_LSL, S_ASR, S_ROR} shift_e;

  typedef struct packed {
    logic c;
    logic z;
    logic n;
    logic v;
  } flags_t;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] d,
  input  logic [W-1:0] s,
  input  logic [W-1:0] mask,
  input  logic         is_byte,
  input  logic         sub,
  input  logic         cin,
  output logic [W-1:0] r,
  output logic         cout,
  output logic         ovf
);
  localparam int H = W / 2;

  logic [W-1:0] s_eff;
  logic [W:0]   sum;
  logic         sd, ss, sr;

  always_comb begin
    s_eff = sub ? (~s & mask) : s;
    sum   = {1'b0, d} + {1'b0, s_eff} + {{W{1'b0}}, cin};
    r     = sum[W-1:0] & mask;
    cout  = is_byte ? sum[H] : sum[W];
    sd    = is_byte ? d[H-1] : d[W-1];
    ss    = is_byte ? s[H-1] : s[W-1];
    sr    = is_byte ? r[H-1] : r[W-1];
    if (sub) ovf = (sd != ss) && (sr != sd);
    else     ovf = (sd == ss) && (sr != sd);
  end
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
  import flag_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] d,
  input  logic [W-1:0] s,
  input  logic [W-1:0] mask,
  input  logic_e       kind,
  output logic [W-1:0] r
);
  always_comb begin
    unique case (kind)
      L_AND:   r = d & s;
      L_ANDN:  r = d & ~s;
      L_OR:    r = d | s;
      default: r = d ^ s;
    endcase
    r = r & mask;
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
  import flag_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] d,
  input  logic [W-1:0] mask,
  input  logic         is_byte,
  input  logic         cin,
  input  shift_e       kind,
  output logic [W-1:0] r,
  output logic         cout
);
  localparam int H  = W / 2;
  localparam int AW = $clog2(W);

  logic [AW-1:0] top;
  logic [W-1:0]  fill;

  always_comb begin
    top  = is_byte ? AW'(H - 1) : AW'(W - 1);
    fill = '0;
    unique case (kind)
      S_LSL: begin
        r    = (d << 1) & mask;
        cout = d[top];
      end
      S_ASR: begin
        fill[top] = d[top];
        r    = (d >> 1) | fill;
        cout = d[0];
      end
      S_ROR: begin
        fill[top] = cin;
        r    = (d >> 1) | fill;
        cout = d[0];
      end
      default: begin
        r    = d >> 1;
        cout = d[0];
      end
    endcase
  end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [3:0]   op_i,
  input  logic         byte_i,
  input  logic [W-1:0] dst_i,
  input  logic [W-1:0] src_i,
  input  logic         c_i,
  input  logic         z_i,
  input  logic         n_i,
  input  logic         v_i,
  output logic [W-1:0] res_o,
  output logic         wr_o,
  output logic         c_o,
  output logic         z_o,
  output logic         n_o,
  output logic         v_o
);
  localparam int H = W / 2;

  alu_op_e      op;
  unit_e        unit;
  logic_e       lkind;
  shift_e       skind;
  logic         sub, cin, wr_d;
  logic [W-1:0] mask, d_m, s_m;
  logic [W-1:0] r_as, r_lg, r_sh, r_d;
  logic         c_as, v_as, c_sh;
  flags_t       fl_d;

  assign op   = alu_op_e'(op_i);
  assign mask = byte_i ? {{(W-H){1'b0}}, {H{1'b1}}} : {W{1'b1}};
  assign d_m  = dst_i & mask;
  assign s_m  = src_i & mask;

  always_comb begin
    unit  = U_NONE;
    sub   = 1'b0;
    cin   = 1'b0;
    lkind = L_AND;
    skind = S_LSR;
    wr_d  = 1'b1;
    unique case (op)
      OP_ADD:  unit = U_ARITH;
      OP_ADDC: begin unit = U_ARITH; cin = c_i; end
      OP_SUB:  begin unit = U_ARITH; sub = 1'b1; cin = 1'b1; end
      OP_SUBB: begin unit = U_ARITH; sub = 1'b1; cin = c_i; end
      OP_CMP:  begin unit = U_ARITH; sub = 1'b1; cin = 1'b1; wr_d = 1'b0; end
      OP_AND:  unit = U_LOGIC;
      OP_TST:  begin unit = U_LOGIC; wr_d = 1'b0; end
      OP_BIC:  begin unit = U_LOGIC; lkind = L_ANDN; end
      OP_BIS:  begin unit = U_LOGIC; lkind = L_OR; end
      OP_XOR:  begin unit = U_LOGIC; lkind = L_XOR; end
      OP_SRL:  unit = U_SHIFT;
      OP_SLL:  begin unit = U_SHIFT; skind = S_LSL; end
      OP_SRA:  begin unit = U_SHIFT; skind = S_ASR; end
      OP_RRC:  begin unit = U_SHIFT; skind = S_ROR; end
      default: wr_d = 1'b0;
    endcase
  end

  alu_addsub #(.W(W)) u_addsub (
    .d(d_m), .s(s_m), .mask(mask), .is_byte(byte_i), .sub(sub), .cin(cin),
    .r(r_as), .cout(c_as), .ovf(v_as)
  );

  alu_bitwise #(.W(W)) u_bitwise (
    .d(d_m), .s(s_m), .mask(mask), .kind(lkind), .r(r_lg)
  );

  alu_shifter #(.W(W)) u_shifter (
    .d(d_m), .mask(mask), .is_byte(byte_i), .cin(c_i), .kind(skind),
    .r(r_sh), .cout(c_sh)
  );

  always_comb begin
    fl_d = '{c: c_i, z: z_i, n: n_i, v: v_i};
    r_d  = '0;
    unique case (unit)
      U_ARITH: r_d = r_as;
      U_LOGIC: r_d = r_lg;
      U_SHIFT: r_d = r_sh;
      default: r_d = '0;
    endcase
    if (unit != U_NONE) begin
      fl_d.z = (r_d == '0);
      fl_d.n = byte_i ? r_d[H-1] : r_d[W-1];
      unique case (unit)
        U_ARITH: begin fl_d.c = c_as; fl_d.v = v_as; end
        U_LOGIC: begin fl_d.c = ~fl_d.z; fl_d.v = 1'b0; end
        default: begin fl_d.c = c_sh; fl_d.v = 1'b0; end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o <= '0;
      wr_o  <= 1'b0;
      c_o   <= 1'b0;
      z_o   <= 1'b0;
      n_o   <= 1'b0;
      v_o   <= 1'b0;
    end else begin
      res_o <= r_d;
      wr_o  <= wr_d;
      c_o   <= fl_d.c;
      z_o   <= fl_d.z;
      n_o   <= fl_d.n;
      v_o   <= fl_d.v;
    end
  end

  // R5
  cmp_tst_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'd4 || op_i == 4'd6) |=> !wr_o);

  // R8
  byte_upper_clear_chk: assert property (@(posedge clk) disable iff (rst)
    byte_i |=> (res_o[W-1:H] == '0));

  // R7
  logic_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i >= 4'd5 && op_i <= 4'd9) |=> (!v_o && (c_o != z_o)));

  // R11
  bad_op_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i >= 4'd14) |=> (!wr_o && res_o == '0 &&
      {c_o, z_o, n_o, v_o} == $past({c_i, z_i, n_i, v_i})));

  // R6
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    wr_o |-> (z_o == (res_o == '0)));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!wr_o && res_o == '0 && {c_o, z_o, n_o, v_o} == 4'b0));
endmodule

// File: tb/flag_alu_tb.sv
`timescale 1ns/1ps
module flag_alu_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op_i = '0;
  logic        byte_i = 1'b0;
  logic [15:0] dst_i = '0, src_i = '0;
  logic        c_i = 1'b0, z_i = 1'b0, n_i = 1'b0, v_i = 1'b0;
  logic [15:0] res_o;
  logic        wr_o, c_o, z_o, n_o, v_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  typedef struct {
    logic [15:0] res;
    logic        wr;
    logic [3:0]  fl;
    string       tag;
  } exp_t;

  exp_t sb[$];

  always #5 clk = ~clk;

  flag_alu #(.W(16)) u_dut (
    .clk(clk), .rst(rst), .op_i(op_i), .byte_i(byte_i), .dst_i(dst_i),
    .src_i(src_i), .c_i(c_i), .z_i(z_i), .n_i(n_i), .v_i(v_i),
    .res_o(res_o), .wr_o(wr_o), .c_o(c_o), .z_o(z_o), .n_o(n_o), .v_o(v_o)
  );

  function automatic exp_t model(input logic [3:0] op, input logic sz,
                                 input logic [15:0] d, input logic [15:0] s,
                                 input logic [3:0] fin, input string tag);
    exp_t e;
    logic [15:0] m, dd, ss, sv, r;
    logic [16:0] sum;
    logic ci, co, vv;
    int hi;
    m  = sz ? 16'h00FF : 16'hFFFF;
    hi = sz ? 7 : 15;
    dd = d & m;
    ss = s & m;
    e.tag = tag;
    e.wr  = 1'b1;
    r = '0; co = 1'b0; vv = 1'b0;
    if (op <= 4'd4) begin
      sv  = (op >= 4'd2) ? (~ss & m) : ss;
      ci  = (op == 4'd0) ? 1'b0 : (op == 4'd2 || op == 4'd4) ? 1'b1 : fin[3];
      sum = {1'b0, dd} + {1'b0, sv} + {16'd0, ci};
      r   = sum[15:0] & m;
      co  = sz ? sum[8] : sum[16];
      if (op >= 4'd2) vv = (dd[hi] != ss[hi]) && (r[hi] != dd[hi]);
      else            vv = (dd[hi] == ss[hi]) && (r[hi] != dd[hi]);
      e.wr = (op != 4'd4);
    end else if (op <= 4'd9) begin
      case (op)
        4'd5, 4'd6: r = dd & ss;
        4'd7:       r = dd & ~ss & m;
        4'd8:       r = dd | ss;
        default:    r = dd ^ ss;
      endcase
      co = (r != 0);
      e.wr = (op != 4'd6);
    end else if (op <= 4'd13) begin
      case (op)
        4'd10: begin r = dd >> 1; co = dd[0]; end
        4'd11: begin r = (dd << 1) & m; co = dd[hi]; end
        4'd12: begin r = dd >> 1; r[hi] = dd[hi]; co = dd[0]; end
        default: begin r = dd >> 1; r[hi] = fin[3]; co = dd[0]; end
      endcase
    end else begin
      e.wr  = 1'b0;
      e.res = '0;
      e.fl  = fin;
      return e;
    end
    e.res = r;
    e.fl  = {co, (r == 0), r[hi], vv};
    return e;
  endfunction

  task automatic drive(input logic [3:0] op, input logic sz,
                       input logic [15:0] d, input logic [15:0] s,
                       input logic [3:0] fin, input string tag);
    @(negedge clk);
    op_i = op; byte_i = sz; dst_i = d; src_i = s;
    {c_i, z_i, n_i, v_i} = fin;
    sb.push_back(model(op, sz, d, s, fin, tag));
  endtask

  // monitor: outputs for the item pushed before an edge appear after it (R12)
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      total++;
      if (res_o !== e.res || wr_o !== e.wr || {c_o, z_o, n_o, v_o} !== e.fl) begin
        bad++;
        $display("FAIL %s R12: got res=%h wr=%b czn v=%b, expected res=%h wr=%b czn v=%b",
                 e.tag, res_o, wr_o, {c_o, z_o, n_o, v_o}, e.res, e.wr, e.fl);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    total++;
    if (res_o !== 16'h0 || wr_o !== 1'b0 || {c_o, z_o, n_o, v_o} !== 4'b0) begin
      bad++;
      $display("FAIL R1 reset: got res=%h wr=%b fl=%b, expected 0 0 0000",
               res_o, wr_o, {c_o, z_o, n_o, v_o});
    end
    @(negedge clk);
    rst = 1'b0;

    drive(4'd0, 0, 16'h1234, 16'h1111, 4'b1000, "R2 add ignores C");
    drive(4'd0, 0, 16'hFFFF, 16'h0001, 4'b0000, "R2 R6 add carry zero");
    drive(4'd1, 0, 16'h00F0, 16'h000F, 4'b1000, "R2 addc with C");
    drive(4'd0, 0, 16'h7FFF, 16'h0001, 4'b0000, "R4 R6 add overflow");
    drive(4'd0, 0, 16'h8000, 16'h8000, 4'b0000, "R4 add neg overflow");
    drive(4'd2, 0, 16'h0005, 16'h0003, 4'b0000, "R3 sub no borrow");
    drive(4'd2, 0, 16'h0003, 16'h0005, 4'b1000, "R3 sub borrow");
    drive(4'd3, 0, 16'h0005, 16'h0003, 4'b0000, "R3 subb C=0");
    drive(4'd3, 0, 16'h0005, 16'h0003, 4'b1000, "R3 subb C=1");
    drive(4'd2, 0, 16'h8000, 16'h0001, 4'b0000, "R4 sub overflow");
    drive(4'd4, 0, 16'h4321, 16'h4321, 4'b0000, "R5 cmp equal");
    drive(4'd4, 0, 16'h0010, 16'h0020, 4'b0000, "R5 cmp less");
    drive(4'd0, 1, 16'h12FF, 16'hAB01, 4'b0000, "R8 byte add carry");
    drive(4'd0, 1, 16'hFF7F, 16'h0001, 4'b0000, "R8 R4 byte overflow");
    drive(4'd2, 1, 16'hAA10, 16'h5520, 4'b0000, "R8 byte sub borrow");
    drive(4'd5, 0, 16'hF0F0, 16'hFF00, 4'b0001, "R7 and");
    drive(4'd6, 0, 16'hF0F0, 16'h0F0F, 4'b0000, "R5 R7 bit test zero");
    drive(4'd6, 1, 16'hFF12, 16'hFF10, 4'b0000, "R5 R8 byte bit test");
    drive(4'd7, 0, 16'h00FF, 16'h0012, 4'b0000, "R7 bit clear");
    drive(4'd8, 0, 16'h0100, 16'h8012, 4'b0000, "R7 R6 bit set neg");
    drive(4'd9, 1, 16'hAB44, 16'h1244, 4'b0001, "R7 R8 byte xor zero");
    drive(4'd10, 0, 16'h8001, 16'h0000, 4'b0000, "R9 lsr word");
    drive(4'd11, 0, 16'h8001, 16'h0000, 4'b0000, "R9 lsl word");
    drive(4'd11, 1, 16'h3380, 16'h0000, 4'b0001, "R9 R8 lsl byte");
    drive(4'd12, 0, 16'h8003, 16'h0000, 4'b0000, "R10 asr word");
    drive(4'd12, 1, 16'h0081, 16'h0000, 4'b0000, "R10 R8 asr byte");
    drive(4'd13, 0, 16'h0002, 16'h0000, 4'b1000, "R10 rrc C=1");
    drive(4'd13, 1, 16'hFF01, 16'h0000, 4'b0000, "R10 R8 rrc byte");
    drive(4'd14, 0, 16'hFFFF, 16'hFFFF, 4'b1010, "R11 unused 14");
    drive(4'd15, 1, 16'h1234, 16'h5678, 4'b0101, "R11 unused 15");

    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule